// File: doc/BRIEF.md
# Latched Register-Select Bus Front End

This block sits between a parallel CPU bus and a peripheral that holds eight byte-wide registers. It turns the raw bus pins into a registered register index and two single-cycle enables: one for reads and one for writes. It also produces a driver-disable level for an external data transceiver. The register contents and the data pads are handled elsewhere.

All bus pins first pass through a two-flop synchroniser. After that, an address strobe controls the three address bits and the three chip selects. While the strobe is low, the address bits and chip selects flow straight through. When the strobe goes high, the last values seen are kept until the strobe drops again. This lets a multiplexed bus present the address early and then reuse those pins.

Read and write each have two inputs, one active-low and one active-high, so either bus polarity can be used. The unused input is tied to its idle level. A cycle in which a read and a write are both asserted is treated as a protocol fault: neither access is performed, and a sticky error flag is raised that only reset clears.

Top module: `bus_select_front`

## Requirements
- R1: The block is selected only when chip-select input A is 1, chip-select input B is 1 and chip-select input C is 0 (effective values after the hold stage). With any other combination, no read enable, no write enable and no transceiver enable is produced.
- R2: While the synchronised address strobe is 0, `reg_sel_o` follows the address inputs 3 clock edges after they change.
- R3: While the address strobe is 1, `reg_sel_o` and the chip-select decode keep the values from the last cycle the strobe was 0. Address and chip-select changes during that time have no effect.
- R4: A read is requested when the block is selected and either `rd_n_i` is 0 or `rd_p_i` is 1.
- R5: A write is requested when the block is selected and either `wr_n_i` is 0 or `wr_p_i` is 1.
- R6: Each read or write request gives exactly one enable pulse, one cycle wide, 3 clock edges after the request appears, however long the request is held.
- R7: `xcvr_off_o` is 1 except while a read request is active. It drops to 0 with the same 3-edge latency as the read enable and returns to 1 after the read ends.
- R8: If a read and a write request are active in the same cycle, neither enable is pulsed and `proto_err_o` becomes 1 and stays 1 until reset.
- R9: While `rst_n` is 0 at a clock edge, `reg_sel_o`=0, `rd_en_o`=0, `wr_en_o`=0, `xcvr_off_o`=1 and `proto_err_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 3 | Register address bits |
| cs_a_i | input | 1 | Chip select A, active high |
| cs_b_i | input | 1 | Chip select B, active high |
| cs_c_i | input | 1 | Chip select C, active low |
| adr_stb_i | input | 1 | Address strobe: 0 = pass through, 1 = hold |
| rd_n_i | input | 1 | Read request, active low |
| rd_p_i | input | 1 | Read request, active high |
| wr_n_i | input | 1 | Write request, active low |
| wr_p_i | input | 1 | Write request, active high |
| reg_sel_o | output | 3 | Registered register index |
| rd_en_o | output | 1 | One-cycle read enable |
| wr_en_o | output | 1 | One-cycle write enable |
| xcvr_off_o | output | 1 | Transceiver driver disable, high when no read is active |
| proto_err_o | output | 1 | Sticky flag for a read and write asserted together |

## Verification
A pin change needs three clock edges to reach any output: two synchroniser flops and one output register. The bench therefore drives all inputs on a falling edge and samples on the third falling edge after that. At that point, a pulse output is in its only high cycle. Pulses are also counted on every falling edge, so the single-pulse rule is checked over long held requests and not only at one sample point. The hold and error cases are read back through `reg_sel_o`, the enables and `proto_err_o` after the stimulus that could have disturbed them.

// File: rtl/bus_fe_pkg.sv
// Shared types for the latched register-select bus front end.
// Assumes: the read/write strobe group is always four bits, two per direction.
package bus_fe_pkg;

    // Synchronised read/write strobe group, one polarity pair per direction.
    typedef struct packed {
        logic rd_n;
        logic rd_p;
        logic wr_n;
        logic wr_p;
    } strb_t;

    localparam strb_t STRB_IDLE = '{rd_n: 1'b1, rd_p: 1'b0, wr_n: 1'b1, wr_p: 1'b0};

    // Chip-select decode: A and B high, C low.
    function automatic logic cs_match(input logic [2:0] cs);
        return cs[2] & cs[1] & ~cs[0];
    endfunction

endpackage

// File: rtl/bfe_sync.sv
// Multi-flop synchroniser for a bus of asynchronous pins.
// Assumes: bits are treated independently; reset forces each bit to RST_VAL.
module bfe_sync #(
    parameter int          WIDTH   = 8,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Shift the bus one flop further down the chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage_q[s] <= RST_VAL;
            end else if (s == 0) begin
                stage_q[s] <= d_i;
            end else begin
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bfe_addr_hold.sv
// Address and chip-select hold stage controlled by the synchronised strobe.
// Strobe low: the inputs pass through. Strobe high: the last low-cycle values are kept.
// Assumes: all inputs come from the same synchroniser, so they arrive together.
module bfe_addr_hold #(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [2:0]        cs_s,
    output logic [ADDR_W-1:0] eff_addr,
    output logic [2:0]        eff_cs
);

    logic [ADDR_W-1:0] held_addr_q;
    logic [2:0]        held_cs_q;

    // Track the inputs while the strobe is low, freeze while it is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_addr_q <= '0;
            held_cs_q   <= 3'b000;
        end else if (!stb_s) begin
            held_addr_q <= addr_s;
            held_cs_q   <= cs_s;
        end
    end

    // Pass through when transparent, otherwise use the held copy.
    always_comb begin
        eff_addr = stb_s ? held_addr_q : addr_s;
        eff_cs   = stb_s ? held_cs_q   : cs_s;
    end

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        stb_s |=> ($stable(held_addr_q) && $stable(held_cs_q))); // R3

endmodule

// File: rtl/bfe_access_gen.sv
// Turns the effective select and the synchronised strobes into registered
// enables, a transceiver disable and a sticky conflict flag.
// Assumes: inputs are already synchronous to clk.
module bfe_access_gen
    import bus_fe_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] eff_addr,
    input  logic [2:0]        eff_cs,
    input  strb_t             strb_s,
    output logic [ADDR_W-1:0] reg_sel_o,
    output logic              rd_en_o,
    output logic              wr_en_o,
    output logic              xcvr_off_o,
    output logic              proto_err_o
);

    logic selected;
    logic rd_act, wr_act, rd_act_q, wr_act_q;
    logic clash, rd_pulse, wr_pulse;

    // Combine chip selects and both strobe polarities into request levels.
    always_comb begin
        selected = cs_match(eff_cs);
        rd_act   = selected & (~strb_s.rd_n | strb_s.rd_p);
        wr_act   = selected & (~strb_s.wr_n | strb_s.wr_p);
        clash    = rd_act & wr_act;
        rd_pulse = rd_act & ~rd_act_q & ~wr_act;
        wr_pulse = wr_act & ~wr_act_q & ~rd_act;
    end

    // Remember the previous request levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_act_q <= 1'b0;
            wr_act_q <= 1'b0;
        end else begin
            rd_act_q <= rd_act;
            wr_act_q <= wr_act;
        end
    end

    // Register the outputs seen by the register file and the pad ring.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_sel_o   <= '0;
            rd_en_o     <= 1'b0;
            wr_en_o     <= 1'b0;
            xcvr_off_o  <= 1'b1;
            proto_err_o <= 1'b0;
        end else begin
            reg_sel_o   <= eff_addr;
            rd_en_o     <= rd_pulse;
            wr_en_o     <= wr_pulse;
            xcvr_off_o  <= ~rd_act;
            proto_err_o <= proto_err_o | clash;
        end
    end

    AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> !rd_en_o); // R6
    AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o); // R6
    AST_NO_DUAL_EN: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en_o && wr_en_o)); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o); // R8
    AST_RD_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |-> !xcvr_off_o); // R7
    AST_SEL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pulse || wr_pulse) |-> selected); // R1

endmodule

// File: rtl/bus_select_front.sv
// Top of the bus front end: synchroniser, address hold stage, access generator.
// Assumes: bus pins are asynchronous to clk and stay stable for at least
// two clock cycles per phase.
module bus_select_front
    import bus_fe_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              cs_a_i,
    input  logic              cs_b_i,
    input  logic              cs_c_i,
    input  logic              adr_stb_i,
    input  logic              rd_n_i,
    input  logic              rd_p_i,
    input  logic              wr_n_i,
    input  logic              wr_p_i,
    output logic [ADDR_W-1:0] reg_sel_o,
    output logic              rd_en_o,
    output logic              wr_en_o,
    output logic              xcvr_off_o,
    output logic              proto_err_o
);

    localparam int BUS_W = 1 + ADDR_W + 3 + $bits(strb_t);
    localparam logic [BUS_W-1:0] BUS_IDLE = {1'b0, {ADDR_W{1'b0}}, 3'b000, STRB_IDLE};

    logic [BUS_W-1:0]  bus_raw, bus_s;
    logic              stb_s;
    logic [ADDR_W-1:0] addr_s, eff_addr;
    logic [2:0]        cs_s, eff_cs;
    strb_t             strb_s;

    assign bus_raw = {adr_stb_i, addr_i, cs_a_i, cs_b_i, cs_c_i,
                      rd_n_i, rd_p_i, wr_n_i, wr_p_i};

    bfe_sync #(
        .WIDTH   (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_raw),
        .q_o   (bus_s)
    );

    assign {stb_s, addr_s, cs_s, strb_s} = bus_s;

    bfe_addr_hold #(
        .ADDR_W (ADDR_W)
    ) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb_s    (stb_s),
        .addr_s   (addr_s),
        .cs_s     (cs_s),
        .eff_addr (eff_addr),
        .eff_cs   (eff_cs)
    );

    bfe_access_gen #(
        .ADDR_W (ADDR_W)
    ) u_access (
        .clk         (clk),
        .rst_n       (rst_n),
        .eff_addr    (eff_addr),
        .eff_cs      (eff_cs),
        .strb_s      (strb_s),
        .reg_sel_o   (reg_sel_o),
        .rd_en_o     (rd_en_o),
        .wr_en_o     (wr_en_o),
        .xcvr_off_o  (xcvr_off_o),
        .proto_err_o (proto_err_o)
    );

endmodule

// File: tb/bus_select_front_bench.sv
`timescale 1ns/1ps
module bus_select_front_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] addr_i;
    logic       cs_a_i, cs_b_i, cs_c_i, adr_stb_i;
    logic       rd_n_i, rd_p_i, wr_n_i, wr_p_i;
    logic [2:0] reg_sel_o;
    logic       rd_en_o, wr_en_o, xcvr_off_o, proto_err_o;

    int total = 0;
    int bad   = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;

    always #4 clk = ~clk;

    bus_select_front u_bus_select_front (
        .clk (clk), .rst_n (rst_n), .addr_i (addr_i),
        .cs_a_i (cs_a_i), .cs_b_i (cs_b_i), .cs_c_i (cs_c_i),
        .adr_stb_i (adr_stb_i), .rd_n_i (rd_n_i), .rd_p_i (rd_p_i),
        .wr_n_i (wr_n_i), .wr_p_i (wr_p_i), .reg_sel_o (reg_sel_o),
        .rd_en_o (rd_en_o), .wr_en_o (wr_en_o), .xcvr_off_o (xcvr_off_o),
        .proto_err_o (proto_err_o)
    );

    // Count enable pulses, once per cycle at the falling edge.
    always @(negedge clk) begin
        if (rd_en_o) rd_cnt <= rd_cnt + 1;
        if (wr_en_o) wr_cnt <= wr_cnt + 1;
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_bus();
        rd_n_i = 1'b1; rd_p_i = 1'b0; wr_n_i = 1'b1; wr_p_i = 1'b0;
    endtask

    task automatic select_on(input logic [2:0] a);
        addr_i = a; cs_a_i = 1'b1; cs_b_i = 1'b1; cs_c_i = 1'b0;
    endtask

    // Wait for the 3-edge latency, ending on a falling edge.
    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic clear_counts();
        @(negedge clk);
        #1;
        rd_cnt = 0;
        wr_cnt = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        adr_stb_i = 1'b0;
        select_on(3'd0);
        idle_bus();
        repeat (3) @(negedge clk);
        check("R9 sel", reg_sel_o, 0);
        check("R9 rd_en", rd_en_o, 0);
        check("R9 wr_en", wr_en_o, 0);
        check("R9 xcvr_off", xcvr_off_o, 1);
        check("R9 err", proto_err_o, 0);
        rst_n = 1'b1;
        settle();
        clear_counts();
    endtask

    task automatic test_read_low();
        select_on(3'd5);
        rd_n_i = 1'b0;
        settle();
        check("R4 rd_en via rd_n", rd_en_o, 1);
        check("R2 sel follows addr", reg_sel_o, 5);
        check("R7 xcvr on during read", xcvr_off_o, 0);
        repeat (10) @(negedge clk);
        check("R7 xcvr stays on", xcvr_off_o, 0);
        #1;
        check("R6 one pulse for long read", rd_cnt, 1);
        rd_n_i = 1'b1;
        settle();
        check("R7 xcvr off after read", xcvr_off_o, 1);
        clear_counts();
    endtask

    task automatic test_read_high();
        select_on(3'd3);
        rd_p_i = 1'b1;
        settle();
        check("R4 rd_en via rd_p", rd_en_o, 1);
        check("R2 sel follows addr", reg_sel_o, 3);
        @(negedge clk);
        check("R6 pulse one cycle", rd_en_o, 0);
        rd_p_i = 1'b0;
        settle();
        clear_counts();
    endtask

    task automatic test_writes();
        select_on(3'd6);
        wr_n_i = 1'b0;
        settle();
        check("R5 wr_en via wr_n", wr_en_o, 1);
        check("R7 xcvr off on write", xcvr_off_o, 1);
        wr_n_i = 1'b1;
        settle();
        select_on(3'd1);
        wr_p_i = 1'b1;
        settle();
        check("R5 wr_en via wr_p", wr_en_o, 1);
        check("R2 sel for write", reg_sel_o, 1);
        wr_p_i = 1'b0;
        settle();
        #1;
        check("R6 two writes two pulses", wr_cnt, 2);
        check("R6 no read from writes", rd_cnt, 0);
        clear_counts();
    endtask

    task automatic test_chip_select();
        for (int c = 0; c < 8; c++) begin
            if (c == 3'b110) continue;
            {cs_a_i, cs_b_i, cs_c_i} = c[2:0];
            addr_i = 3'd2;
            settle();
            rd_n_i = 1'b0;
            settle();
            check("R1 xcvr stays off unselected", xcvr_off_o, 1);
            rd_n_i = 1'b1;
            wr_p_i = 1'b1;
            settle();
            wr_p_i = 1'b0;
            settle();
        end
        #1;
        check("R1 no read when unselected", rd_cnt, 0);
        check("R1 no write when unselected", wr_cnt, 0);
        select_on(3'd0);
        settle();
        clear_counts();
    endtask

    task automatic test_hold();
        select_on(3'd2);
        adr_stb_i = 1'b0;
        settle();
        adr_stb_i = 1'b1;
        settle();
        addr_i = 3'd7;
        cs_a_i = 1'b0; cs_c_i = 1'b1;
        settle();
        check("R3 sel held", reg_sel_o, 2);
        rd_n_i = 1'b0;
        settle();
        check("R3 held select still active", rd_en_o, 1);
        check("R3 held addr on read", reg_sel_o, 2);
        rd_n_i = 1'b1;
        settle();
        select_on(3'd7);
        adr_stb_i = 1'b0;
        settle();
        check("R2 sel follows after release", reg_sel_o, 7);
        clear_counts();
    endtask

    task automatic test_conflict();
        select_on(3'd4);
        rd_n_i = 1'b0;
        wr_p_i = 1'b1;
        settle();
        check("R8 err set", proto_err_o, 1);
        idle_bus();
        repeat (6) @(negedge clk);
        check("R8 err sticky", proto_err_o, 1);
        #1;
        check("R8 no read pulse", rd_cnt, 0);
        check("R8 no write pulse", wr_cnt, 0);
        do_reset();
        check("R9 err cleared by reset", proto_err_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        adr_stb_i = 1'b0;
        select_on(3'd0);
        idle_bus();
        @(negedge clk);
        do_reset();
        test_read_low();
        test_read_high();
        test_writes();
        test_chip_select();
        test_hold();
        test_conflict();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule